// File: doc/BRIEF.md
# SPI Slave with Selectable Select Source

This block is the receive/transmit engine of an SPI slave. It runs on a system clock and oversamples the serial lines. An internal active-low select gates all shifting. A control input picks where that select comes from: either the external select pin, or a software select bit. When the software bit is in use the pin has no effect and can serve other purposes. A device acting as bus master holds the select inactive by enabling software management with the select bit at 1.

Both clock polarities and both clock phases are supported. Data moves MSB first. Each completed byte is handed to a holding register together with a one-cycle ready strobe.

With phase 0, the slave has to see the select go inactive between bytes before it may load its next transmit byte. If the host writes the transmit register after a finished byte while the select is still active, the write is dropped and a sticky collision flag is raised. With phase 1, the select may stay active across any number of bytes, and writes between bytes are accepted.

Top module: `spi_sel_slave`

## Requirements
- R1: With `ssm_i`=0 the internal select follows the synchronised `ss_ni` pin. With `ssm_i`=1 it equals `ssi_i` (0 = selected, 1 = deselected), and `ss_ni` has no effect on any output.
- R2: While the internal select is 1, `miso_oe_o` is 0 and `miso_o` is 0. While it is 0, `miso_oe_o` is 1.
- R3: Bits are received MSB first. After the eighth sampling edge, `rx_data_o` holds the byte and `rx_valid_o` is high for exactly one clock cycle.
- R4: With `cpha_i`=0, MOSI is sampled on the leading SCK edge. The transmit MSB appears on `miso_o` as soon as the select becomes active, and the next bit follows each trailing edge.
- R5: With `cpha_i`=1, `miso_o` moves to the next bit on each leading SCK edge and MOSI is sampled on each trailing edge.
- R6: `cpol_i` gives the SCK idle level. With 0, the leading edge is rising. With 1, the leading edge is falling.
- R7: With `cpha_i`=1 the select may stay active across consecutive bytes. Transmit writes between those bytes are accepted and never raise `wcol_o`.
- R8: With `cpha_i`=0, a `tx_wr_i` after a completed byte, with the select still active since that byte, sets `wcol_o`. The written value is discarded and the transmit shift register keeps its contents. Once the select has gone inactive, a write is accepted.
- R9: `wcol_o` stays set until a `wcol_clr_i` pulse clears it.
- R10: When the select goes inactive, the bit counter returns to zero. A partial byte produces no `rx_valid_o`, and the next byte is framed from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| ss_ni | input | 1 | Select pin, active low |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | MISO drive enable; 0 means released |
| ssm_i | input | 1 | 1 = software select source |
| ssi_i | input | 1 | Software select level, 0 = selected |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | Clock phase |
| tx_wr_i | input | 1 | Transmit data write strobe |
| tx_data_i | input | 8 | Transmit byte |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle received-byte strobe |
| wcol_o | output | 1 | Sticky write-collision flag |
| wcol_clr_i | input | 1 | Clears the collision flag |

## Verification
SCK, MOSI and the select pin each pass through two synchroniser flops. A pin change therefore reaches the shift registers, `rx_data_o` and `rx_valid_o` on the second clock edge after the one that first samples it. `ssi_i` and `ssm_i` act on `miso_oe_o` within the same cycle, and a write or collision shows up on `wcol_o` one edge after the strobe. The bench holds every SCK phase for four clocks, so each result has settled before it is sampled. A reference model of the select path predicts `miso_oe_o` and `miso_o` one nanosecond after every rising edge, using its own two-stage history of the pin.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;
  parameter int unsigned SPI_W = 8;
  parameter int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic sel_n;
    logic lead;
    logic trail;
  } spi_evt_t;
endpackage

// File: rtl/spi_sel_sync.sv
module spi_sel_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_sel_front.sv
module spi_sel_front
  import spi_sel_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sck_s_i,
  input  logic     ss_s_i,
  input  logic     ssm_i,
  input  logic     ssi_i,
  input  logic     cpol_i,
  output spi_evt_t evt_o
);
  logic sck_n, sck_n_q;

  // normalise so that 1 means "away from idle"
  assign sck_n = sck_s_i ^ cpol_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sck_n_q <= 1'b0;
    else         sck_n_q <= sck_n;

  assign evt_o.sel_n = ssm_i ? ssi_i : ss_s_i;
  assign evt_o.lead  =  sck_n & ~sck_n_q;
  assign evt_o.trail = ~sck_n &  sck_n_q;
endmodule

// File: rtl/spi_sel_core.sv
module spi_sel_core
  import spi_sel_pkg::*;
#(
  parameter int unsigned W = SPI_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  spi_evt_t     evt_i,
  input  logic         mosi_s_i,
  input  logic         cpha_i,
  input  logic         tx_load_i,
  input  logic [W-1:0] tx_data_i,
  output logic         miso_o,
  output logic [W-1:0] rx_data_o,
  output logic         rx_valid_o,
  output logic         byte_done_o
);
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     rx_sr_q, tx_sr_q, rx_next;
  logic             sample, shift;

  assign sample  = cpha_i ? evt_i.trail : evt_i.lead;
  // phase 1: first leading edge of a byte presents the MSB without shifting
  assign shift   = cpha_i ? (evt_i.lead && cnt_q != '0) : evt_i.trail;
  assign rx_next = {rx_sr_q[W-2:0], mosi_s_i};
  assign byte_done_o = ~evt_i.sel_n & sample & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q      <= '0;
      rx_sr_q    <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (evt_i.sel_n) begin
        cnt_q <= '0;
      end else if (sample) begin
        rx_sr_q <= rx_next;
        if (cnt_q == LAST) begin
          cnt_q      <= '0;
          rx_data_o  <= rx_next;
          rx_valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                      tx_sr_q <= '0;
    else if (tx_load_i)               tx_sr_q <= tx_data_i;
    else if (!evt_i.sel_n && shift)   tx_sr_q <= {tx_sr_q[W-2:0], 1'b0};

  assign miso_o = tx_sr_q[W-1];

  // R10
  cnt_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.sel_n |=> (cnt_q == '0));
  // R3
  rx_valid_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> ($past(cnt_q) == LAST));
  // R3
  rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

// File: rtl/spi_sel_wcol.sv
module spi_sel_wcol (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_n_i,
  input  logic cpha_i,
  input  logic byte_done_i,
  input  logic tx_wr_i,
  input  logic wcol_clr_i,
  output logic tx_load_o,
  output logic wcol_o
);
  logic done_hold_q, collide;

  // select has stayed active since the last finished byte
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          done_hold_q <= 1'b0;
    else if (sel_n_i)     done_hold_q <= 1'b0;
    else if (byte_done_i) done_hold_q <= 1'b1;

  assign collide   = tx_wr_i & ~cpha_i & ~sel_n_i & done_hold_q;
  assign tx_load_o = tx_wr_i & ~collide;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         wcol_o <= 1'b0;
    else if (collide)    wcol_o <= 1'b1;
    else if (wcol_clr_i) wcol_o <= 1'b0;

  // R9
  wcol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcol_o && !wcol_clr_i) |=> wcol_o);
  // R9
  wcol_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcol_clr_i && !collide) |=> !wcol_o);
  // R8
  wcol_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_i && !tx_load_o) |=> wcol_o);
endmodule

// File: rtl/spi_sel_slave.sv
module spi_sel_slave
  import spi_sel_pkg::*;
#(
  parameter int unsigned W = SPI_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sck_i,
  input  logic         mosi_i,
  input  logic         ss_ni,
  output logic         miso_o,
  output logic         miso_oe_o,
  input  logic         ssm_i,
  input  logic         ssi_i,
  input  logic         cpol_i,
  input  logic         cpha_i,
  input  logic         tx_wr_i,
  input  logic [W-1:0] tx_data_i,
  output logic [W-1:0] rx_data_o,
  output logic         rx_valid_o,
  output logic         wcol_o,
  input  logic         wcol_clr_i
);
  logic [2:0] pins_s;
  spi_evt_t   evt;
  logic       tx_load, byte_done, miso_bit;

  // order: {ss, mosi, sck}; select resets inactive
  spi_sel_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b100)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, mosi_i, sck_i}),
    .q_o   (pins_s)
  );

  spi_sel_front i_front (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_s_i(pins_s[0]),
    .ss_s_i (pins_s[2]),
    .ssm_i  (ssm_i),
    .ssi_i  (ssi_i),
    .cpol_i (cpol_i),
    .evt_o  (evt)
  );

  spi_sel_wcol i_wcol (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_n_i    (evt.sel_n),
    .cpha_i     (cpha_i),
    .byte_done_i(byte_done),
    .tx_wr_i    (tx_wr_i),
    .wcol_clr_i (wcol_clr_i),
    .tx_load_o  (tx_load),
    .wcol_o     (wcol_o)
  );

  spi_sel_core #(.W(W)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .mosi_s_i   (pins_s[1]),
    .cpha_i     (cpha_i),
    .tx_load_i  (tx_load),
    .tx_data_i  (tx_data_i),
    .miso_o     (miso_bit),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .byte_done_o(byte_done)
  );

  assign miso_oe_o = ~evt.sel_n;
  assign miso_o    = miso_bit & ~evt.sel_n;

  // R1
  soft_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ssm_i && ssi_i) |-> !miso_oe_o);
  // R2
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miso_oe_o |-> !miso_o);
endmodule

// File: tb/test_spi_sel_slave.sv
`timescale 1ns/1ps
module test_spi_sel_slave;
  logic clk = 0, rst_n = 0;
  logic sck = 0, mosi = 0, ss = 1, ssm = 0, ssi = 1, cpol = 0, cpha = 0;
  logic tx_wr = 0, wclr = 0;
  logic [7:0] tx_data = '0;
  logic miso_o, miso_oe_o, rx_valid_o, wcol_o;
  logic [7:0] rx_data_o;
  int n_chk = 0, n_err = 0, pulses = 0, cyc = 0;
  logic h1 = 1, h2 = 1;

  always #4 clk = ~clk;

  spi_sel_slave i_spi_sel_slave (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .ss_ni(ss),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .ssm_i(ssm), .ssi_i(ssi),
    .cpol_i(cpol), .cpha_i(cpha), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .wcol_o(wcol_o),
    .wcol_clr_i(wclr)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  endtask

  // reference model of the select path: two-stage pin history
  always @(posedge clk) begin
    if (!rst_n) begin h1 <= 1; h2 <= 1; end
    else begin h1 <= ss; h2 <= h1; end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      logic exp_sel_n;
      exp_sel_n = ssm ? ssi : h2;
      chk(miso_oe_o == !exp_sel_n, "R1/R2 select-oe", miso_oe_o, !exp_sel_n);
      if (exp_sel_n) chk(miso_o == 0, "R2 released-miso", miso_o, 0);
    end
  end

  always @(negedge clk) if (rx_valid_o) pulses++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_tx(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic xfer(input logic [7:0] m, input int nbits, output logic [7:0] s);
    s = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!cpha) begin
        mosi = m[i]; tick(4); s[i] = miso_o;
        sck = ~cpol; tick(4); sck = cpol;
      end else begin
        sck = ~cpol; mosi = m[i]; tick(4); s[i] = miso_o;
        sck = cpol; tick(4);
      end
    end
    tick(4);
  endtask

  initial begin
    logic [7:0] s;
    int p0;
    tick(3); rst_n = 1; tick(2);
    // reset state
    chk(rx_valid_o == 0, "R3 reset rx_valid", rx_valid_o, 0);
    chk(rx_data_o == 0, "R3 reset rx_data", rx_data_o, 0);
    chk(wcol_o == 0, "R9 reset wcol", wcol_o, 0);
    chk(miso_oe_o == 0, "R2 reset oe", miso_oe_o, 0);

    // R4 R6: phase 0, idle low
    wr_tx(8'h3C); ss = 0; tick(4); p0 = pulses;
    xfer(8'hA5, 8, s);
    chk(s == 8'h3C, "R4 miso byte", s, 8'h3C);
    chk(rx_data_o == 8'hA5, "R3 rx byte", rx_data_o, 8'hA5);
    chk(pulses == p0 + 1, "R3 one strobe", pulses - p0, 1);
    ss = 1; tick(4);

    // R5 R6: phase 1, idle high
    cpol = 1; sck = 1; tick(4); cpha = 1;
    wr_tx(8'h96); ss = 0; tick(4);
    xfer(8'h4D, 8, s);
    chk(s == 8'h96, "R5 miso byte", s, 8'h96);
    chk(rx_data_o == 8'h4D, "R6 rx byte cpol1", rx_data_o, 8'h4D);

    // R7: select held, writes between bytes
    wr_tx(8'h81); tick(2);
    chk(wcol_o == 0, "R7 no wcol", wcol_o, 0);
    xfer(8'h5A, 8, s);
    chk(s == 8'h81, "R7 miso 1st", s, 8'h81);
    chk(rx_data_o == 8'h5A, "R7 rx 1st", rx_data_o, 8'h5A);
    wr_tx(8'h7E); tick(2); p0 = pulses;
    xfer(8'hC3, 8, s);
    chk(s == 8'h7E, "R7 miso 2nd", s, 8'h7E);
    chk(rx_data_o == 8'hC3, "R7 rx 2nd", rx_data_o, 8'hC3);
    chk(wcol_o == 0, "R7 wcol clear", wcol_o, 0);
    chk(pulses == p0 + 1, "R7 strobe", pulses - p0, 1);
    ss = 1; tick(4);

    // R8 R9: phase 0 collision
    cpol = 0; sck = 0; tick(4); cpha = 0;
    wr_tx(8'hE7); ss = 0; tick(4);
    xfer(8'h12, 8, s);
    chk(s == 8'hE7, "R8 miso before", s, 8'hE7);
    wr_tx(8'hFF); tick(2);
    chk(wcol_o == 1, "R8 wcol set", wcol_o, 1);
    ss = 1; tick(4);
    chk(wcol_o == 1, "R9 wcol sticky", wcol_o, 1);
    ss = 0; tick(4);
    xfer(8'h34, 8, s);
    chk(s == 8'h00, "R8 write discarded", s, 8'h00);
    chk(rx_data_o == 8'h34, "R8 rx after", rx_data_o, 8'h34);
    ss = 1; tick(4);
    @(negedge clk); wclr = 1; @(negedge clk); wclr = 0; tick(2);
    chk(wcol_o == 0, "R9 wcol cleared", wcol_o, 0);
    wr_tx(8'hAA); tick(2);
    chk(wcol_o == 0, "R8 write after deselect", wcol_o, 0);
    ss = 0; tick(4);
    xfer(8'h00, 8, s);
    chk(s == 8'hAA, "R8 accepted byte", s, 8'hAA);
    ss = 1; tick(4);

    // R10: partial byte then deselect
    ss = 0; tick(4); p0 = pulses;
    xfer(8'hF0, 4, s);
    ss = 1; tick(4);
    chk(pulses == p0, "R10 no strobe", pulses - p0, 0);
    ss = 0; tick(4);
    xfer(8'h69, 8, s);
    chk(rx_data_o == 8'h69, "R10 realigned", rx_data_o, 8'h69);
    chk(pulses == p0 + 1, "R10 one strobe", pulses - p0, 1);
    ss = 1; tick(4);

    // R1: software select
    ssm = 1; ssi = 1; ss = 0; tick(4); p0 = pulses;
    xfer(8'h55, 8, s);
    chk(pulses == p0, "R1 pin ignored", pulses - p0, 0);
    ss = 1; wr_tx(8'hC6); ssi = 0; tick(4);
    xfer(8'h2B, 8, s);
    chk(s == 8'hC6, "R1 soft miso", s, 8'hC6);
    chk(rx_data_o == 8'h2B, "R1 soft rx", rx_data_o, 8'h2B);
    ssi = 1; tick(4);
    finish_run();
  end
endmodule